// File: doc/BRIEF.md
# Dual Warp Issue Scheduler

This block is the issue stage of a streaming multiprocessor. It holds a set of resident warps, each tracked by a single program counter. Two schedulers run side by side: scheduler 0 serves the even-numbered warps and scheduler 1 the odd-numbered ones. Each scheduler picks one ready warp per opportunity and sends that warp's current instruction to its own lane group. A lane group is narrower than a warp, so the instruction goes out as a series of thread slices on consecutive cycles. With the default widths of 32 threads and 16 lanes, threads 0 to 15 go out first and threads 16 to 31 follow.

A third lane group can be enabled and is shared by the two schedulers. When a scheduler issues a warp, it can also place that warp's following instruction on the shared group in the same cycle. This happens only if the two instructions have no register conflict and their combined source operands fit within the operand-port budget for that cycle. A warp's counter moves forward only after every slice of its issued work has gone out. It moves by one for a single issue and by two for a dual issue.

The environment supplies per-warp ready flags and two instruction descriptors per warp: the current instruction and the one after it. Each descriptor carries a tag, a destination register, source registers and a source count. The block returns one strobe per lane group, giving the warp id, the instruction tag and the slice index.

Top module: `dual_warp_issue`

## Requirements
- R1: After the active-low reset, no group strobe is asserted and every warp counter reads zero.
- R2: An issued instruction yields exactly WARP_THREADS/GROUP_LANES strobes on one group in consecutive cycles. The slice index runs 0, 1, … in order, and warp id and tag stay unchanged across the strobes.
- R3: Group 0 carries only even warps and group 1 only odd warps. A warp picked in cycle t shows slice 0 in cycle t+1, and both groups may show slice 0 of different warps in the same cycle.
- R4: A warp's counter changes only on the clock edge that ends the cycle in which its last slice is shown. The warp is not picked again before that counter is visible.
- R5: Each scheduler picks among its eligible warps in round-robin order, starting after the warp it last issued. After reset the lowest warp of each subset comes first.
- R6: A dual issue shows the second instruction's tag on group 2 for the same warp, in the same cycle as the primary's slice 0. The counter then advances by two.
- R7: Dual issue is blocked when a valid source of the second instruction equals the first's destination. Source 0 counts as valid when the source count is at least 1, and source 1 when it is at least 2.
- R8: Dual issue is blocked when the two instructions have the same destination register.
- R9: Dual issue is blocked when the primary's source count plus the second's source count exceeds the operand budget input.
- R10: When both schedulers request group 2 while it is free, it is granted to scheduler 0 when the turn bit is 0 and to scheduler 1 when it is 1. The turn bit resets to 0 and toggles every cycle. The losing scheduler still issues its primary instruction, and exactly one warp gets the group.
- R11: A warp whose ready flag is low is never issued.
- R12: A group accepts a new instruction only when it is idle or is showing its last slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_ready | input | NUM_WARPS | Per-warp ready flag |
| pri_itag | input | NUM_WARPS*ITAG_W | Current instruction tag per warp |
| pri_dst | input | NUM_WARPS*RT_W | Current instruction destination register |
| pri_nsrc | input | NUM_WARPS*2 | Current instruction source count (0..2) |
| sec_valid | input | NUM_WARPS | Following instruction is a dual-issue candidate |
| sec_itag | input | NUM_WARPS*ITAG_W | Following instruction tag |
| sec_dst | input | NUM_WARPS*RT_W | Following instruction destination register |
| sec_src0 | input | NUM_WARPS*RT_W | Following instruction first source |
| sec_src1 | input | NUM_WARPS*RT_W | Following instruction second source |
| sec_nsrc | input | NUM_WARPS*2 | Following instruction source count |
| opnd_budget | input | BUD_W | Source operands available this cycle |
| grp_vld | output | NUM_GRP | Slice strobe per lane group |
| grp_warp | output | NUM_GRP*WID_W | Warp id on each group |
| grp_itag | output | NUM_GRP*ITAG_W | Instruction tag on each group |
| grp_slice | output | NUM_GRP*SL_W | Thread-slice index on each group |
| warp_pc | output | NUM_WARPS*PC_W | Program counter per warp |

## Verification
Some properties are checked on every cycle inside the RTL. Each open slice must step to the next index with the same warp and tag, and a group may start only when it is free. A counter may move only just after that warp's last slice, a shared-group strobe must pair with a primary slice 0 of the same warp, and a contested shared group must go to the scheduler whose turn it is. The directed scenarios cover what needs known stimulus. That includes the exact tags and latency, the decision taken by each independence and budget gate, the size of each counter step, and the round-robin order over a held set of ready warps.

// File: rtl/dwi_pkg.sv
package dwi_pkg;
   // lane group roles
   typedef enum logic [1:0] {
      GRP_EVEN   = 2'd0,
      GRP_ODD    = 2'd1,
      GRP_SHARED = 2'd2
   } grp_role_e;

   // number of cycles one warp instruction occupies a group
   function automatic int slice_count(input int threads, input int lanes);
      return threads / lanes;
   endfunction
endpackage

// File: rtl/dwi_rr_pick.sv
module dwi_rr_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic          gnt_vld,
   output logic [IW-1:0] gnt_idx
);
   always_comb begin
      gnt_vld = 1'b0;
      gnt_idx = '0;
      for (int k = 1; k <= N; k++) begin
         if (!gnt_vld && req[(int'(last) + k) % N]) begin
            gnt_vld = 1'b1;
            gnt_idx = IW'((int'(last) + k) % N);
         end
      end
   end
endmodule

// File: rtl/dwi_dual_gate.sv
module dwi_dual_gate #(
   parameter int RT_W  = 5,
   parameter int NS_W  = 2,
   parameter int BUD_W = 3
) (
   input  logic             sec_v,
   input  logic [RT_W-1:0]  p_dst,
   input  logic [NS_W-1:0]  p_nsrc,
   input  logic [RT_W-1:0]  s_dst,
   input  logic [RT_W-1:0]  s_src0,
   input  logic [RT_W-1:0]  s_src1,
   input  logic [NS_W-1:0]  s_nsrc,
   input  logic [BUD_W-1:0] budget,
   output logic             ok
);
   localparam int SUM_W = ((NS_W > BUD_W) ? NS_W : BUD_W) + 1;

   logic             raw0, raw1, waw, fits;
   logic [SUM_W-1:0] need;

   always_comb begin
      raw0 = (s_nsrc >= NS_W'(1)) && (s_src0 == p_dst);
      raw1 = (s_nsrc >= NS_W'(2)) && (s_src1 == p_dst);
      waw  = (s_dst == p_dst);
      need = SUM_W'(p_nsrc) + SUM_W'(s_nsrc);
      fits = (need <= SUM_W'(budget));
      ok   = sec_v && !raw0 && !raw1 && !waw && fits;
   end
endmodule

// File: rtl/dwi_lane_group.sv
module dwi_lane_group #(
   parameter int WID_W  = 3,
   parameter int ITAG_W = 8,
   parameter int SLICES = 2,
   parameter int SL_W   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [WID_W-1:0]  l_warp,
   input  logic [ITAG_W-1:0] l_itag,
   output logic              act,
   output logic [WID_W-1:0]  warp,
   output logic [ITAG_W-1:0] itag,
   output logic [SL_W-1:0]   slice,
   output logic              free,
   output logic              last
);
   localparam logic [SL_W-1:0] LAST_SL = SL_W'(SLICES - 1);

   logic              act_q;
   logic [WID_W-1:0]  warp_q;
   logic [ITAG_W-1:0] itag_q;
   logic [SL_W-1:0]   slice_q;

   assign last = act_q && (slice_q == LAST_SL);
   assign free = !act_q || last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         warp_q  <= '0;
         itag_q  <= '0;
         slice_q <= '0;
      end else if (launch) begin
         act_q   <= 1'b1;
         warp_q  <= l_warp;
         itag_q  <= l_itag;
         slice_q <= '0;
      end else if (act_q && !last) begin
         slice_q <= slice_q + 1'b1;
      end else begin
         act_q <= 1'b0;
      end
   end

   assign act   = act_q;
   assign warp  = warp_q;
   assign itag  = itag_q;
   assign slice = slice_q;

   // R2
   slice_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !last) |=> (act_q && slice_q == $past(slice_q) + 1'b1 &&
                            $stable(warp_q) && $stable(itag_q)));

   // R12
   accept_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && slice_q == '0) |-> $past(!act_q || slice_q == LAST_SL));
endmodule

// File: rtl/dual_warp_issue.sv
module dual_warp_issue #(
   parameter int NUM_WARPS    = 8,
   parameter int WARP_THREADS = 32,
   parameter int GROUP_LANES  = 16,
   parameter bit SHARED_GROUP = 1'b1,
   parameter int ITAG_W       = 8,
   parameter int RT_W         = 5,
   parameter int PC_W         = 8,
   parameter int BUD_W        = 3,
   localparam int NUM_GRP     = SHARED_GROUP ? 3 : 2,
   localparam int SLICES      = WARP_THREADS / GROUP_LANES,
   localparam int SL_W        = (SLICES > 1) ? $clog2(SLICES) : 1,
   localparam int WID_W       = $clog2(NUM_WARPS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_WARPS-1:0]          warp_ready,
   input  logic [NUM_WARPS*ITAG_W-1:0]   pri_itag,
   input  logic [NUM_WARPS*RT_W-1:0]     pri_dst,
   input  logic [NUM_WARPS*2-1:0]        pri_nsrc,
   input  logic [NUM_WARPS-1:0]          sec_valid,
   input  logic [NUM_WARPS*ITAG_W-1:0]   sec_itag,
   input  logic [NUM_WARPS*RT_W-1:0]     sec_dst,
   input  logic [NUM_WARPS*RT_W-1:0]     sec_src0,
   input  logic [NUM_WARPS*RT_W-1:0]     sec_src1,
   input  logic [NUM_WARPS*2-1:0]        sec_nsrc,
   input  logic [BUD_W-1:0]              opnd_budget,
   output logic [NUM_GRP-1:0]            grp_vld,
   output logic [NUM_GRP*WID_W-1:0]      grp_warp,
   output logic [NUM_GRP*ITAG_W-1:0]     grp_itag,
   output logic [NUM_GRP*SL_W-1:0]       grp_slice,
   output logic [NUM_WARPS*PC_W-1:0]     warp_pc
);
   import dwi_pkg::*;

   localparam int HALF  = NUM_WARPS / 2;
   localparam int HID_W = $clog2(HALF);
   localparam int NS_W  = 2;

   // elaboration-time parameter checks
   if (slice_count(WARP_THREADS, GROUP_LANES) * GROUP_LANES != WARP_THREADS ||
       SLICES < 2) begin : g_bad_slices
      $error("warp width must be a multiple (>=2) of the lane group width");
   end
   if (NUM_WARPS < 4 || (NUM_WARPS & (NUM_WARPS - 1)) != 0) begin : g_bad_warps
      $error("NUM_WARPS must be a power of two, at least 4");
   end

   // scheduler side
   logic [1:0]        pv, launch, req2, dual_ok, grant2;
   logic [HID_W-1:0]  pidx  [2];
   logic [HID_W-1:0]  ptr_q [2];
   logic [WID_W-1:0]  pw    [2];
   logic [ITAG_W-1:0] s_tag [2];

   // lane group side
   logic [NUM_GRP-1:0] g_launch, g_act, g_free, g_last;
   logic [WID_W-1:0]   g_lwarp [NUM_GRP];
   logic [ITAG_W-1:0]  g_litag [NUM_GRP];
   logic [WID_W-1:0]   g_warp  [NUM_GRP];
   logic [ITAG_W-1:0]  g_itag  [NUM_GRP];
   logic [SL_W-1:0]    g_slice [NUM_GRP];

   // warp state
   logic [NUM_WARPS-1:0]           busy_q, dual_q;
   logic [NUM_WARPS-1:0][PC_W-1:0] pc_q;
   logic [NUM_WARPS-1:0]           fin_hit, launch_hit, dual_hit;

   for (genvar s = 0; s < 2; s++) begin : g_sched
      logic [HALF-1:0] elig;

      for (genvar i = 0; i < HALF; i++) begin : g_elig
         assign elig[i] = warp_ready[2*i+s] && !busy_q[2*i+s];
      end

      dwi_rr_pick #(.N(HALF), .IW(HID_W)) pick_i (
         .req     (elig),
         .last    (ptr_q[s]),
         .gnt_vld (pv[s]),
         .gnt_idx (pidx[s])
      );

      assign pw[s]     = WID_W'(2 * int'(pidx[s]) + s);
      assign s_tag[s]  = sec_itag[pw[s]*ITAG_W +: ITAG_W];

      dwi_dual_gate #(.RT_W(RT_W), .NS_W(NS_W), .BUD_W(BUD_W)) gate_i (
         .sec_v  (sec_valid[pw[s]]),
         .p_dst  (pri_dst [pw[s]*RT_W +: RT_W]),
         .p_nsrc (pri_nsrc[pw[s]*NS_W +: NS_W]),
         .s_dst  (sec_dst [pw[s]*RT_W +: RT_W]),
         .s_src0 (sec_src0[pw[s]*RT_W +: RT_W]),
         .s_src1 (sec_src1[pw[s]*RT_W +: RT_W]),
         .s_nsrc (sec_nsrc[pw[s]*NS_W +: NS_W]),
         .budget (opnd_budget),
         .ok     (dual_ok[s])
      );

      assign launch[s]   = pv[s] && g_free[s];
      assign req2[s]     = launch[s] && dual_ok[s];
      assign g_launch[s] = launch[s];
      assign g_lwarp[s]  = pw[s];
      assign g_litag[s]  = pri_itag[pw[s]*ITAG_W +: ITAG_W];

      always_ff @(posedge clk) begin
         if (!rst_n)         ptr_q[s] <= HID_W'(HALF - 1);
         else if (launch[s]) ptr_q[s] <= pidx[s];
      end

      // R3
      issue_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         launch[s] |=> (g_act[s] && g_slice[s] == '0 && g_warp[s] == $past(pw[s])));
   end

   if (SHARED_GROUP) begin : g_shared
      logic par_q;

      always_ff @(posedge clk) begin
         if (!rst_n) par_q <= 1'b0;
         else        par_q <= !par_q;
      end

      assign grant2[0] = req2[0] && g_free[2] && (!req2[1] || !par_q);
      assign grant2[1] = req2[1] && g_free[2] && (!req2[0] ||  par_q);

      assign g_launch[2] = |grant2;
      assign g_lwarp[2]  = grant2[1] ? pw[1]    : pw[0];
      assign g_litag[2]  = grant2[1] ? s_tag[1] : s_tag[0];

      // R6
      pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (g_act[2] && g_slice[2] == '0) |->
            ((g_act[0] && g_slice[0] == '0 && g_warp[0] == g_warp[2]) ||
             (g_act[1] && g_slice[1] == '0 && g_warp[1] == g_warp[2])));

      // R10
      shared_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req2 == 2'b11 && g_free[2]) |=> (g_warp[2][0] == $past(par_q)));
   end else begin : g_noshared
      assign grant2 = '0;
   end

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      dwi_lane_group #(
         .WID_W(WID_W), .ITAG_W(ITAG_W), .SLICES(SLICES), .SL_W(SL_W)
      ) grp_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .launch (g_launch[g]),
         .l_warp (g_lwarp[g]),
         .l_itag (g_litag[g]),
         .act    (g_act[g]),
         .warp   (g_warp[g]),
         .itag   (g_itag[g]),
         .slice  (g_slice[g]),
         .free   (g_free[g]),
         .last   (g_last[g])
      );

      assign grp_vld[g]                    = g_act[g];
      assign grp_warp [g*WID_W  +: WID_W]  = g_warp[g];
      assign grp_itag [g*ITAG_W +: ITAG_W] = g_itag[g];
      assign grp_slice[g*SL_W   +: SL_W]   = g_slice[g];
   end

   always_comb begin
      fin_hit    = '0;
      launch_hit = '0;
      dual_hit   = '0;
      for (int g = 0; g < NUM_GRP; g++)
         if (g_last[g]) fin_hit[g_warp[g]] = 1'b1;
      for (int s = 0; s < 2; s++) begin
         if (launch[s]) launch_hit[pw[s]] = 1'b1;
         if (grant2[s]) dual_hit[pw[s]]   = 1'b1;
      end
   end

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp_st
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_q[w] <= 1'b0;
            dual_q[w] <= 1'b0;
            pc_q[w]   <= '0;
         end else if (fin_hit[w]) begin
            busy_q[w] <= 1'b0;
            pc_q[w]   <= pc_q[w] + (dual_q[w] ? PC_W'(2) : PC_W'(1));
         end else if (launch_hit[w]) begin
            busy_q[w] <= 1'b1;
            dual_q[w] <= dual_hit[w];
         end
      end

      // R4
      pc_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(pc_q[w]) |-> $past(fin_hit[w]));
   end

   assign warp_pc = pc_q;
endmodule

// File: tb/dual_warp_issue_tb_top.sv
`timescale 1ns/1ps
module dual_warp_issue_tb_top;
   localparam int NW     = 8;
   localparam int ITAG_W = 8;
   localparam int RT_W   = 5;
   localparam int PC_W   = 8;
   localparam int BUD_W  = 3;
   localparam int NG     = 3;
   localparam int WID_W  = 3;
   localparam int SL_W   = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NW-1:0]          warp_ready = '0;
   logic [NW*ITAG_W-1:0]   pri_itag = '0;
   logic [NW*RT_W-1:0]     pri_dst = '0;
   logic [NW*2-1:0]        pri_nsrc = '0;
   logic [NW-1:0]          sec_valid = '0;
   logic [NW*ITAG_W-1:0]   sec_itag = '0;
   logic [NW*RT_W-1:0]     sec_dst = '0;
   logic [NW*RT_W-1:0]     sec_src0 = '0;
   logic [NW*RT_W-1:0]     sec_src1 = '0;
   logic [NW*2-1:0]        sec_nsrc = '0;
   logic [BUD_W-1:0]       opnd_budget = '0;
   logic [NG-1:0]          grp_vld;
   logic [NG*WID_W-1:0]    grp_warp;
   logic [NG*ITAG_W-1:0]   grp_itag;
   logic [NG*SL_W-1:0]     grp_slice;
   logic [NW*PC_W-1:0]     warp_pc;

   dual_warp_issue dut_i (
      .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready),
      .pri_itag(pri_itag), .pri_dst(pri_dst), .pri_nsrc(pri_nsrc),
      .sec_valid(sec_valid), .sec_itag(sec_itag), .sec_dst(sec_dst),
      .sec_src0(sec_src0), .sec_src1(sec_src1), .sec_nsrc(sec_nsrc),
      .opnd_budget(opnd_budget), .grp_vld(grp_vld), .grp_warp(grp_warp),
      .grp_itag(grp_itag), .grp_slice(grp_slice), .warp_pc(warp_pc)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   function automatic int gv(input int g);  return int'(grp_vld[g]); endfunction
   function automatic int gw(input int g);  return int'(grp_warp[g*WID_W +: WID_W]); endfunction
   function automatic int gt(input int g);  return int'(grp_itag[g*ITAG_W +: ITAG_W]); endfunction
   function automatic int gs(input int g);  return int'(grp_slice[g*SL_W +: SL_W]); endfunction
   function automatic int pc(input int w);  return int'(warp_pc[w*PC_W +: PC_W]); endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic set_pri(input int w, input int tag, input int dst, input int ns);
      pri_itag[w*ITAG_W +: ITAG_W] = ITAG_W'(tag);
      pri_dst [w*RT_W +: RT_W]     = RT_W'(dst);
      pri_nsrc[w*2 +: 2]           = 2'(ns);
   endtask

   task automatic set_sec(input int w, input bit v, input int tag, input int dst,
                          input int s0, input int s1, input int ns);
      sec_valid[w]                 = v;
      sec_itag[w*ITAG_W +: ITAG_W] = ITAG_W'(tag);
      sec_dst [w*RT_W +: RT_W]     = RT_W'(dst);
      sec_src0[w*RT_W +: RT_W]     = RT_W'(s0);
      sec_src1[w*RT_W +: RT_W]     = RT_W'(s1);
      sec_nsrc[w*2 +: 2]           = 2'(ns);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      warp_ready = '0;
      sec_valid = '0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   // R1
   task automatic t_reset();
      int sum = 0;
      do_reset();
      chk("R1", "group strobes after reset", int'(grp_vld), 0);
      for (int w = 0; w < NW; w++) sum += pc(w);
      chk("R1", "sum of counters after reset", sum, 0);
   endtask

   // R2 R3 R4 R11
   task automatic t_single();
      int p0 = pc(0);
      set_pri(0, 8'h11, 3, 1);
      set_sec(0, 1'b0, 0, 0, 0, 0, 0);
      warp_ready[0] = 1'b1;
      step();
      chk("R3", "g0 strobe one cycle after pick", gv(0), 1);
      chk("R2", "first slice index", gs(0), 0);
      chk("R2", "tag on first slice", gt(0), 8'h11);
      chk("R11", "g1 idle with no odd warp ready", gv(1), 0);
      warp_ready[0] = 1'b0;
      step();
      chk("R2", "second slice index", gs(0), 1);
      chk("R2", "tag on second slice", gt(0), 8'h11);
      chk("R4", "counter held during last slice", pc(0), p0);
      step();
      chk("R2", "no third strobe", gv(0), 0);
      chk("R4", "counter after last slice", pc(0), (p0 + 1) % 256);
   endtask

   // R3
   task automatic t_pair();
      set_pri(0, 8'h30, 1, 0);
      set_pri(1, 8'h31, 2, 0);
      warp_ready[1:0] = 2'b11;
      step();
      chk("R3", "both groups strobe together", int'(grp_vld[1:0]), 3);
      chk("R3", "g0 warp even", gw(0), 0);
      chk("R3", "g1 warp odd", gw(1), 1);
      warp_ready = '0;
      step();
      step();
   endtask

   // one warp, decide dual or not
   task automatic run_one(input int w, input bit exp_dual, input string req);
      int p0 = pc(w);
      int g  = w % 2;
      warp_ready[w] = 1'b1;
      step();
      chk(req, "primary slice 0 strobe", gv(g) && gs(g) == 0 && gw(g) == w, 1);
      chk(req, "shared group strobe", gv(2), int'(exp_dual));
      if (exp_dual) begin
         chk(req, "shared group tag", gt(2), int'(sec_itag[w*ITAG_W +: ITAG_W]));
         chk(req, "shared group warp", gw(2), w);
      end
      warp_ready[w] = 1'b0;
      step();
      step();
      chk(req, "counter step", (pc(w) - p0 + 256) % 256, exp_dual ? 2 : 1);
   endtask

   // R6 R7 R8 R9
   task automatic t_gates();
      opnd_budget = 3'd4;
      set_pri(2, 8'h20, 4, 2);
      set_sec(2, 1'b1, 8'h21, 5, 6, 7, 2);
      run_one(2, 1'b1, "R6");
      set_sec(2, 1'b1, 8'h22, 5, 4, 7, 1);
      run_one(2, 1'b0, "R7");
      set_sec(2, 1'b1, 8'h23, 5, 6, 4, 1);
      run_one(2, 1'b1, "R7");
      set_sec(2, 1'b1, 8'h24, 5, 6, 4, 2);
      run_one(2, 1'b0, "R7");
      set_sec(2, 1'b1, 8'h25, 4, 6, 7, 2);
      run_one(2, 1'b0, "R8");
      opnd_budget = 3'd3;
      set_sec(2, 1'b1, 8'h26, 5, 6, 7, 2);
      run_one(2, 1'b0, "R9");
      set_sec(2, 1'b1, 8'h27, 5, 6, 7, 1);
      run_one(2, 1'b1, "R9");
      set_sec(2, 1'b0, 0, 0, 0, 0, 0);
   endtask

   // R10
   task automatic t_contend();
      int a0 = pc(0);
      int a1 = pc(1);
      int win;
      opnd_budget = 3'd4;
      set_pri(0, 8'h40, 1, 1);
      set_sec(0, 1'b1, 8'h41, 2, 3, 3, 1);
      set_pri(1, 8'h50, 1, 1);
      set_sec(1, 1'b1, 8'h51, 2, 3, 3, 1);
      warp_ready[1:0] = 2'b11;
      step();
      chk("R10", "shared group granted", gv(2), 1);
      win = gw(2);
      chk("R10", "winner is a contender", int'(win == 0 || win == 1), 1);
      chk("R10", "both primaries issued", int'(grp_vld[1:0]), 3);
      warp_ready = '0;
      step();
      step();
      chk("R10", "warp 0 step", (pc(0) - a0 + 256) % 256, win == 0 ? 2 : 1);
      chk("R10", "warp 1 step", (pc(1) - a1 + 256) % 256, win == 1 ? 2 : 1);
      set_sec(0, 1'b0, 0, 0, 0, 0, 0);
      set_sec(1, 1'b0, 0, 0, 0, 0, 0);
   endtask

   // R5 R11 R12
   task automatic t_rr();
      int seq[6];
      int n = 0;
      int exp_seq[6] = '{0, 2, 4, 0, 2, 4};
      int saw6 = 0;
      int gaps = 0;
      do_reset();
      for (int w = 0; w < NW; w++) set_pri(w, 8'h60 + w, w, 0);
      warp_ready = 8'b0001_0101;
      for (int c = 0; c < 13; c++) begin
         step();
         if (!gv(0)) gaps++;
         if (gv(0) && gw(0) == 6) saw6++;
         if (gv(0) && gs(0) == 0 && n < 6) begin
            seq[n] = gw(0);
            n++;
         end
      end
      chk("R5", "slice-0 issues seen", n, 6);
      for (int i = 0; i < 6; i++) chk("R5", "round-robin order", seq[i], exp_seq[i]);
      chk("R11", "unready warp 6 issued", saw6, 0);
      chk("R12", "back-to-back issue without gaps", gaps, 0);
      warp_ready = '0;
      repeat (4) step();
   endtask

   initial begin
      #(200_000 * 5);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL all: watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_single();
      t_pair();
      t_gates();
      t_contend();
      t_rr();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule